// File: doc/BRIEF.md
# USB Dual-Role Interrupt Status Register

This block collects event strobes from the host and device engines of a dual-role USB controller. It latches them into a bank of sticky status bits and raises a single interrupt line through a per-bit enable mask. The status bits mean different things in host mode and in device mode. An event that belongs only to the other mode is dropped. In host mode a system bus error also sends a one-cycle request to clear the controller's run/stop bit.

The block also keeps a 14-bit microframe index. The index advances on each 125 µs tick while the controller runs. A programmable list-size selector picks which index bit marks a wrap of the frame list. When that bit toggles, the rollover status bit sets.

Software reaches the block through a plain register port. Writes take effect on the clock edge and reads are combinational. The port has no back-pressure: every access completes in the cycle it is presented. Register addresses are: 0 status, 1 enable, 2 frame index (read-only). Any other address reads as zero.

Top module: `usb_irq_status`

## Requirements
- R1: After reset the status bits, enable bits, frame index, `irq` and `run_clear` are all 0.
- R2: Status bit positions are: 0 frame tick/SOF, 1 port change, 2 rollover, 3 system error, 4 async advance, 5 bus reset, 6 suspend. A status bit clears only when address 0 is written with a 1 in that bit position. Writing a 0 leaves the bit unchanged.
- R3: When a set event and a clear write reach the same bit in the same cycle, the bit stays set.
- R4: In host mode, bit 0 sets on a microframe tick only when `phy_clk_on` is 1 and `port_susp` is 0.
- R5: In device mode, bit 0 sets when a start of frame is seen, or when the expected SOF is late.
- R6: In device mode, bit 5 sets on a bus reset. Bit 6 sets only on a 0-to-1 change of `dev_suspended`, not while it stays high.
- R7: Bit 4 (async advance) sets only in host mode.
- R8: A system error sets bit 3 in both modes. In host mode only, `run_clear` is high during the single cycle after the error is sampled.
- R9: The frame index increments by one on each tick while `running` is 1. Otherwise it holds its value.
- R10: In host mode, bit 2 sets when an increment toggles index bit 13 minus `list_sel` (`list_sel` values 0 to 3 select bits 13 to 10).
- R11: In host mode, bit 1 sets on a connect change, an enable change or a forced resume. In device mode it sets on entry to full or high speed.
- R12: `irq` is 1 exactly when some status bit and its enable bit (address 1, same positions) are both 1.
- R13: An event that belongs to the other mode leaves the status bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_mode | input | 1 | 1 = host role, 0 = device role |
| phy_clk_on | input | 1 | PHY clock present |
| port_susp | input | 1 | Host port suspended |
| running | input | 1 | Run/stop state of the controller |
| list_sel | input | 2 | Frame list size select (0 = largest) |
| uframe_tick | input | 1 | 125 µs microframe strobe |
| sof_seen | input | 1 | Device: SOF detected |
| sof_late | input | 1 | Device: expected SOF overdue |
| bus_reset | input | 1 | Device: bus reset detected |
| dev_suspended | input | 1 | Device: suspend state level |
| async_adv | input | 1 | Host: async schedule advanced after doorbell |
| sys_err | input | 1 | System bus error strobe |
| conn_chg | input | 1 | Host: connect status change |
| en_chg | input | 1 | Host: port enable change |
| resume_jk | input | 1 | Host: resume forced by J-K transition |
| speed_entry | input | 1 | Device: entered FS/HS operation |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| irq | output | 1 | Interrupt request |
| run_clear | output | 1 | One-cycle request to clear run/stop |

## Verification
The rollover is the hardest condition to reach from the ports. It needs the index to be walked more than a thousand ticks to the exact edge of the selected bit. It must also be checked that the bit stays quiet one tick earlier. The stimulus holds the tick strobe high for a counted run, reads the index and status just short of the toggle, clears the status, and then adds one tick. The same walk is repeated with a second list size. The same-cycle collision between an event and a clear is produced by asserting the tick strobe and the clear write on the same edge.

// File: rtl/usb_sts_pkg.sv
package usb_sts_pkg;
  localparam int STS_W  = 7;
  localparam int ADDR_W = 2;
  localparam int B_SOF  = 0;
  localparam int B_PORT = 1;
  localparam int B_ROLL = 2;
  localparam int B_SERR = 3;
  localparam int B_AADV = 4;
  localparam int B_URST = 5;
  localparam int B_SUSP = 6;
  localparam logic [ADDR_W-1:0] A_STS = 2'd0;
  localparam logic [ADDR_W-1:0] A_EN  = 2'd1;
  localparam logic [ADDR_W-1:0] A_IDX = 2'd2;
  typedef logic [STS_W-1:0] sts_vec_t;
endpackage

// File: rtl/usb_evt_qualify.sv
module usb_evt_qualify
  import usb_sts_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     host_mode,
  input  logic     phy_clk_on,
  input  logic     port_susp,
  input  logic     uframe_tick,
  input  logic     sof_seen,
  input  logic     sof_late,
  input  logic     bus_reset,
  input  logic     dev_suspended,
  input  logic     async_adv,
  input  logic     sys_err,
  input  logic     conn_chg,
  input  logic     en_chg,
  input  logic     resume_jk,
  input  logic     speed_entry,
  input  logic     roll_evt,
  output sts_vec_t set_vec
);
  logic susp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) susp_q <= 1'b0;
    else        susp_q <= dev_suspended;
  end

  always_comb begin
    set_vec = '0;
    if (host_mode) begin
      set_vec[B_SOF]  = uframe_tick & phy_clk_on & ~port_susp;
      set_vec[B_PORT] = conn_chg | en_chg | resume_jk;
      set_vec[B_ROLL] = roll_evt;
      set_vec[B_AADV] = async_adv;
    end else begin
      set_vec[B_SOF]  = sof_seen | sof_late;
      set_vec[B_PORT] = speed_entry;
      set_vec[B_URST] = bus_reset;
      set_vec[B_SUSP] = dev_suspended & ~susp_q;
    end
    set_vec[B_SERR] = sys_err;
  end
endmodule

// File: rtl/usb_frame_index.sv
module usb_frame_index #(
  parameter int IDX_W   = 14,
  parameter int LSEL_W  = 2,
  parameter int TOP_BIT = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              running,
  input  logic [LSEL_W-1:0] list_sel,
  output logic [IDX_W-1:0]  idx,
  output logic              roll
);
  localparam int SEL_W = $clog2(IDX_W);

  logic [IDX_W-1:0] nxt;
  logic [SEL_W-1:0] sel;
  logic             adv;

  assign adv = tick & running;
  assign nxt = idx + 1'b1;
  assign sel = SEL_W'(TOP_BIT) - SEL_W'(list_sel);
  assign roll = adv & (idx[sel] != nxt[sel]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx <= '0;
    else if (adv) idx <= nxt;
  end
endmodule

// File: rtl/usb_w1c_bank.sv
module usb_w1c_bank #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q[i] <= 1'b0;
      else if (set_vec[i]) q[i] <= 1'b1;
      else if (clr_vec[i]) q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/usb_irq_status.sv
module usb_irq_status
  import usb_sts_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 14,
  parameter int LSEL_W  = 2,
  parameter int TOP_BIT = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_mode,
  input  logic              phy_clk_on,
  input  logic              port_susp,
  input  logic              running,
  input  logic [LSEL_W-1:0] list_sel,
  input  logic              uframe_tick,
  input  logic              sof_seen,
  input  logic              sof_late,
  input  logic              bus_reset,
  input  logic              dev_suspended,
  input  logic              async_adv,
  input  logic              sys_err,
  input  logic              conn_chg,
  input  logic              en_chg,
  input  logic              resume_jk,
  input  logic              speed_entry,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              run_clear
);
  sts_vec_t         set_vec, clr_vec, sts, en_q;
  logic [IDX_W-1:0] frame_idx;
  logic             roll_evt;
  logic             run_clr_q;

  usb_frame_index #(.IDX_W(IDX_W), .LSEL_W(LSEL_W), .TOP_BIT(TOP_BIT)) u_idx (
    .clk(clk), .rst_n(rst_n), .tick(uframe_tick), .running(running),
    .list_sel(list_sel), .idx(frame_idx), .roll(roll_evt)
  );

  usb_evt_qualify u_qual (
    .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .phy_clk_on(phy_clk_on),
    .port_susp(port_susp), .uframe_tick(uframe_tick), .sof_seen(sof_seen),
    .sof_late(sof_late), .bus_reset(bus_reset), .dev_suspended(dev_suspended),
    .async_adv(async_adv), .sys_err(sys_err), .conn_chg(conn_chg),
    .en_chg(en_chg), .resume_jk(resume_jk), .speed_entry(speed_entry),
    .roll_evt(roll_evt), .set_vec(set_vec)
  );

  assign clr_vec = (reg_wr && reg_addr == A_STS) ? reg_wdata[STS_W-1:0] : '0;

  usb_w1c_bank #(.W(STS_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .q(sts)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= '0;
      run_clr_q <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_EN) en_q <= reg_wdata[STS_W-1:0];
      run_clr_q <= sys_err & host_mode;
    end
  end

  always_comb begin
    case (reg_addr)
      A_STS:   reg_rdata = DATA_W'(sts);
      A_EN:    reg_rdata = DATA_W'(en_q);
      A_IDX:   reg_rdata = DATA_W'(frame_idx);
      default: reg_rdata = '0;
    endcase
  end

  assign irq       = |(sts & en_q);
  assign run_clear = run_clr_q;
endmodule

// File: rtl/usb_irq_status_chk.sv
module usb_irq_status_chk
  import usb_sts_pkg::*;
#(
  parameter int IDX_W  = 14,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_mode,
  input logic              sys_err,
  input logic              run_clear,
  input logic              irq,
  input logic              uframe_tick,
  input logic              running,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input sts_vec_t          sts,
  input logic [IDX_W-1:0]  frame_idx
);
  // R8
  run_clear_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_err && host_mode) |=> run_clear);
  // R8
  run_clear_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_mode && !sys_err) |=> !run_clear);
  // R3
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_err |=> sts[B_SERR]);
  // R2
  zero_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_STS && !reg_wdata[B_SERR] && sts[B_SERR]) |=> sts[B_SERR]);
  // R9
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(uframe_tick && running) |=> $stable(frame_idx));
  // R12
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sts != '0));
  // R13
  async_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_mode && !sts[B_AADV]) |=> !sts[B_AADV]);
endmodule

bind usb_irq_status usb_irq_status_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .sys_err(sys_err),
  .run_clear(run_clear), .irq(irq), .uframe_tick(uframe_tick),
  .running(running), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .sts(sts), .frame_idx(frame_idx)
);

// File: tb/usb_irq_status_tb_top.sv
module usb_irq_status_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_mode = 1'b1, phy_clk_on = 1'b1, port_susp = 1'b0, running = 1'b0;
  logic [1:0] list_sel = 2'd0;
  logic uframe_tick = 0, sof_seen = 0, sof_late = 0, bus_reset = 0, dev_suspended = 0;
  logic async_adv = 0, sys_err = 0, conn_chg = 0, en_chg = 0, resume_jk = 0, speed_entry = 0;
  logic reg_wr = 0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq, run_clear;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_irq_status dut_i (
    .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .phy_clk_on(phy_clk_on),
    .port_susp(port_susp), .running(running), .list_sel(list_sel),
    .uframe_tick(uframe_tick), .sof_seen(sof_seen), .sof_late(sof_late),
    .bus_reset(bus_reset), .dev_suspended(dev_suspended), .async_adv(async_adv),
    .sys_err(sys_err), .conn_chg(conn_chg), .en_chg(en_chg),
    .resume_jk(resume_jk), .speed_entry(speed_entry), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .run_clear(run_clear)
  );

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Monitor: compares the oldest expectation away from the active edge
  always @(negedge clk) begin
    if (q.size() != 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        1:       act = {31'd0, irq};
        2:       act = {31'd0, run_clear};
        default: act = reg_rdata;
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic expect_val(int kind, logic [1:0] addr, logic [31:0] exp, string tag);
    reg_addr = addr;
    q.push_back('{kind, exp, tag});
    step();
  endtask

  task automatic wr(logic [1:0] addr, logic [31:0] data);
    reg_wr = 1'b1; reg_addr = addr; reg_wdata = data;
    step();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  // 0 tick,1 sof,2 late,3 reset,4 async,5 err,6 conn,7 en,8 jk,9 speed
  task automatic fire(int which);
    case (which)
      0: uframe_tick = 1;  1: sof_seen = 1;  2: sof_late = 1;
      3: bus_reset = 1;    4: async_adv = 1; 5: sys_err = 1;
      6: conn_chg = 1;     7: en_chg = 1;    8: resume_jk = 1;
      default: speed_entry = 1;
    endcase
    step();
    {uframe_tick, sof_seen, sof_late, bus_reset, async_adv, sys_err,
     conn_chg, en_chg, resume_jk, speed_entry} = '0;
  endtask

  task automatic ticks(int n);
    uframe_tick = 1;
    repeat (n) step();
    uframe_tick = 0;
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < WDOG_CYC) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    expect_val(0, 2'd0, 32'h0, "R1 status");
    expect_val(0, 2'd1, 32'h0, "R1 enable");
    expect_val(0, 2'd2, 32'h0, "R1 index");
    expect_val(1, 2'd0, 32'h0, "R1 irq");
    expect_val(2, 2'd0, 32'h0, "R1 run_clear");

    // R4 host tick, R9 index holds while stopped
    fire(0);
    expect_val(0, 2'd0, 32'h01, "R4 host sof");
    expect_val(0, 2'd2, 32'h0, "R9 idle index");
    // R2 write zero, then write one
    wr(2'd0, 32'h0);
    expect_val(0, 2'd0, 32'h01, "R2 write0 keeps");
    wr(2'd0, 32'h01);
    expect_val(0, 2'd0, 32'h00, "R2 write1 clears");
    // R4 gating
    port_susp = 1; fire(0); port_susp = 0;
    expect_val(0, 2'd0, 32'h00, "R4 suspended port");
    phy_clk_on = 0; fire(0); phy_clk_on = 1;
    expect_val(0, 2'd0, 32'h00, "R4 no phy clock");
    // R7 async advance in host mode
    fire(4);
    expect_val(0, 2'd0, 32'h10, "R7 async host");
    wr(2'd0, 32'h7F);
    // R11 host port change sources
    fire(6); expect_val(0, 2'd0, 32'h02, "R11 conn"); wr(2'd0, 32'h02);
    fire(7); expect_val(0, 2'd0, 32'h02, "R11 enable"); wr(2'd0, 32'h02);
    fire(8); expect_val(0, 2'd0, 32'h02, "R11 resume"); wr(2'd0, 32'h02);
    fire(9); expect_val(0, 2'd0, 32'h00, "R13 speed in host");
    // R13 device-only events in host mode
    fire(1); fire(2); fire(3);
    dev_suspended = 1; step(); dev_suspended = 0; step();
    expect_val(0, 2'd0, 32'h00, "R13 device events in host");
    // R8 host system error
    sys_err = 1; step(); sys_err = 0;
    expect_val(2, 2'd0, 32'h1, "R8 run_clear host");
    expect_val(0, 2'd0, 32'h08, "R8 error bit host");
    expect_val(2, 2'd0, 32'h0, "R8 run_clear one cycle");
    // R12 interrupt masking
    expect_val(1, 2'd0, 32'h0, "R12 masked");
    wr(2'd1, 32'h08);
    expect_val(1, 2'd0, 32'h1, "R12 enabled");
    wr(2'd1, 32'h04);
    expect_val(1, 2'd0, 32'h0, "R12 other enable");
    wr(2'd1, 32'h00);
    wr(2'd0, 32'h08);
    // R3 event wins over clear
    fire(0);
    uframe_tick = 1; reg_wr = 1; reg_addr = 2'd0; reg_wdata = 32'h01;
    step();
    uframe_tick = 0; reg_wr = 0; reg_wdata = '0;
    expect_val(0, 2'd0, 32'h01, "R3 event wins");
    wr(2'd0, 32'h01);

    // R9 / R10 rollover, list_sel 3 -> bit 10
    running = 1; list_sel = 2'd3;
    ticks(1023);
    expect_val(0, 2'd2, 32'd1023, "R9 index count");
    expect_val(0, 2'd0, 32'h01, "R10 no roll before bit10");
    wr(2'd0, 32'h7F);
    ticks(1);
    expect_val(0, 2'd0, 32'h05, "R10 roll bit10");
    wr(2'd0, 32'h7F);
    // list_sel 2 -> bit 11
    list_sel = 2'd2;
    ticks(1023);
    expect_val(0, 2'd0, 32'h01, "R10 no roll before bit11");
    wr(2'd0, 32'h7F);
    ticks(1);
    expect_val(0, 2'd2, 32'd2048, "R9 index 2048");
    expect_val(0, 2'd0, 32'h05, "R10 roll bit11");
    wr(2'd0, 32'h7F);
    running = 0;
    ticks(3);
    expect_val(0, 2'd2, 32'd2048, "R9 hold when stopped");
    wr(2'd0, 32'h7F);

    // Device mode
    host_mode = 0; step();
    fire(0);
    expect_val(0, 2'd0, 32'h00, "R13 host tick in device");
    fire(1); expect_val(0, 2'd0, 32'h01, "R5 sof seen"); wr(2'd0, 32'h01);
    fire(2); expect_val(0, 2'd0, 32'h01, "R5 sof late"); wr(2'd0, 32'h01);
    fire(3); expect_val(0, 2'd0, 32'h20, "R6 bus reset"); wr(2'd0, 32'h20);
    dev_suspended = 1; step();
    expect_val(0, 2'd0, 32'h40, "R6 suspend edge");
    wr(2'd0, 32'h40);
    step();
    expect_val(0, 2'd0, 32'h00, "R6 held suspend no reset");
    dev_suspended = 0;
    fire(9); expect_val(0, 2'd0, 32'h02, "R11 speed entry"); wr(2'd0, 32'h02);
    fire(6); fire(4);
    expect_val(0, 2'd0, 32'h00, "R7 R13 host events in device");
    sys_err = 1; step(); sys_err = 0;
    expect_val(2, 2'd0, 32'h0, "R8 no run_clear device");
    expect_val(0, 2'd0, 32'h08, "R8 error bit device");
    step(); step();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule